// File: doc/BRIEF.md
# Serial channel clock-mode pin selector

This block decides, for one serial channel, where the transmit clock and the receive clock come from. It also decides whether the transmit-clock pin is an input or is driven, and what it carries when driven. The choice depends on a 3-bit clock mode and two control bits. The direction bit turns the transmit-clock pin into a driven output. The source-select bit routes the baud-rate generator clock to the transmit side in the modes that allow it. The block also tells the baud-rate generator whether to count from the receive-clock pin or from the crystal oscillator.

The baud-rate generator, the recovered-clock circuit, the oscillator and the time-slot counter live outside this block. Their clocks and the transmit time-slot window arrive here as plain inputs. Inside, the selection itself is purely combinational, so every output follows its chosen source directly.

The configuration arrives through a write strobe and is first held in a pending copy. The pending copy becomes the active setting only on a clock edge where the channel reports that it is idle. This keeps the clock selection from changing in the middle of a transfer.

Top module: `clk_mode_sel`

## Requirements
- R1: After reset the active setting is mode 0 with the direction bit clear and the source-select bit clear. In that state txclk_pin_oe=0, txclk_pin_out=0, tx_clk follows txclk_pin_in and rx_clk follows rxclk_pin_in.
- R2: A write (cfg_wr=1) is captured on a rising clk edge. It becomes active on the first later rising edge at which chan_idle=1. While chan_idle=0 the previous setting stays in force.
- R3: txclk_pin_oe equals the active direction bit. While the direction bit is clear, txclk_pin_out is 0.
- R4: With the direction bit and the source-select bit both clear:
  - in modes 0, 2 and 6, tx_clk follows txclk_pin_in;
  - in mode 1, tx_strobe follows txclk_pin_in and tx_clk follows rxclk_pin_in.
  - In every other setting tx_strobe is 0.
- R5: With the direction bit set and the source-select bit set, in modes 2 and 6, both txclk_pin_out and tx_clk follow brg_clk.
- R6: With the direction bit set and the source-select bit clear:
  - in modes 3 and 7, txclk_pin_out and tx_clk follow dpll_clk;
  - in mode 4, txclk_pin_out and tx_clk follow osc_clk;
  - in mode 5, txclk_pin_out follows tslot_win and tx_clk follows rxclk_pin_in.
- R7: rx_clk is selected from the mode alone:
  - rxclk_pin_in in modes 0, 1 and 5;
  - brg_clk in modes 2 and 6;
  - dpll_clk in modes 3 and 7;
  - osc_clk in mode 4.
- R8: brg_from_osc is 1 in modes 4, 6 and 7 (the receive-clock pin is a crystal connection) and 0 in modes 0 to 3 and 5.
- R9: Any setting not covered by R4 to R6 takes tx_clk from rxclk_pin_in, and txclk_pin_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Clock mode to write |
| cfg_dir | input | 1 | Transmit-clock pin direction bit to write (1 = driven) |
| cfg_src | input | 1 | Source-select bit to write |
| chan_idle | input | 1 | Channel idle; pending setting is applied only while high |
| txclk_pin_in | input | 1 | Level seen on the transmit-clock pin |
| rxclk_pin_in | input | 1 | Level seen on the receive-clock pin |
| brg_clk | input | 1 | Baud-rate generator output clock |
| dpll_clk | input | 1 | Recovered clock from the DPLL |
| osc_clk | input | 1 | Crystal oscillator clock |
| tslot_win | input | 1 | Transmit time-slot window |
| tx_clk | output | 1 | Selected internal transmit clock |
| rx_clk | output | 1 | Selected internal receive clock |
| tx_strobe | output | 1 | Transmit strobe taken from the pin in mode 1 |
| txclk_pin_out | output | 1 | Value driven onto the transmit-clock pin |
| txclk_pin_oe | output | 1 | Output enable of the transmit-clock pin |
| brg_from_osc | output | 1 | Baud-rate generator counts from the oscillator (1) or from the receive-clock pin (0) |

## Verification
Three properties are checked by the assertions on every cycle:
- the active setting changes only after an idle cycle;
- the pin drive value stays low whenever the enable is low;
- the strobe and the oscillator-source flag are asserted only in their own modes.

The receive-clock path in mode 0 is also checked on every cycle. Only the bench's scenarios show that each of the 32 settings routes the correct source to each output. The bench drives all 64 combinations of the six source inputs to show this. The bench alone also shows that a write made while the channel is busy is held back and then applied once the channel goes idle.

// File: rtl/clk_mode_sel.sv
module clk_mode_sel #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_dir,
  input  logic              cfg_src,
  input  logic              chan_idle,
  input  logic              txclk_pin_in,
  input  logic              rxclk_pin_in,
  input  logic              brg_clk,
  input  logic              dpll_clk,
  input  logic              osc_clk,
  input  logic              tslot_win,
  output logic              tx_clk,
  output logic              rx_clk,
  output logic              tx_strobe,
  output logic              txclk_pin_out,
  output logic              txclk_pin_oe,
  output logic              brg_from_osc
);

  localparam int CFG_W = MODE_W + 2;

  logic [CFG_W-1:0]  pend_q, act_q;
  logic              pend_vld_q;
  logic [MODE_W-1:0] mode_q;
  logic              dir_q, src_q;

  assign {mode_q, dir_q, src_q} = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      act_q      <= '0;
    end else begin
      if (cfg_wr) begin
        pend_q     <= {cfg_mode, cfg_dir, cfg_src};
        pend_vld_q <= 1'b1;
      end else if (pend_vld_q && chan_idle) begin
        pend_vld_q <= 1'b0;
      end
      if (pend_vld_q && chan_idle && !cfg_wr)
        act_q <= pend_q;
    end
  end

  logic pin_sel, pin_val;

  always_comb begin
    tx_clk  = rxclk_pin_in;
    pin_sel = 1'b0;
    pin_val = 1'b0;
    if (!dir_q && !src_q) begin
      case (mode_q)
        3'd0, 3'd2, 3'd6: tx_clk = txclk_pin_in;
        default:          tx_clk = rxclk_pin_in;
      endcase
    end else if (dir_q && src_q) begin
      if (mode_q == 3'd2 || mode_q == 3'd6) begin
        tx_clk  = brg_clk;
        pin_sel = 1'b1;
        pin_val = brg_clk;
      end
    end else if (dir_q) begin
      case (mode_q)
        3'd3, 3'd7: begin tx_clk = dpll_clk; pin_sel = 1'b1; pin_val = dpll_clk; end
        3'd4:       begin tx_clk = osc_clk;  pin_sel = 1'b1; pin_val = osc_clk;  end
        3'd5:       begin pin_sel = 1'b1; pin_val = tslot_win; end
        default:    pin_sel = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (mode_q)
      3'd2, 3'd6: rx_clk = brg_clk;
      3'd3, 3'd7: rx_clk = dpll_clk;
      3'd4:       rx_clk = osc_clk;
      default:    rx_clk = rxclk_pin_in;
    endcase
  end

  assign tx_strobe     = (mode_q == 3'd1) && !dir_q && !src_q && txclk_pin_in;
  assign txclk_pin_oe  = dir_q;
  assign txclk_pin_out = dir_q && pin_sel && pin_val;
  assign brg_from_osc  = (mode_q == 3'd4) || (mode_q == 3'd6) || (mode_q == 3'd7);

  assert_idle_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(chan_idle));

  assert_pin_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !txclk_pin_oe |-> (txclk_pin_out == 1'b0));

  assert_strobe_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> (mode_q == 3'd1 && !txclk_pin_oe && txclk_pin_in));

  assert_rx_pin_mode0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0) |-> (rx_clk == rxclk_pin_in));

  assert_osc_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brg_from_osc |-> (mode_q[2] && (mode_q != 3'd5)));

endmodule

// File: tb/tb_clk_mode_sel.sv
`timescale 1ns/1ps
module tb_clk_mode_sel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_dir = 1'b0, cfg_src = 1'b0, chan_idle = 1'b1;
  logic [2:0] cfg_mode = 3'd0;
  logic txi = 0, rxi = 0, brg = 0, dpll = 0, osc = 0, tsl = 0;
  logic tx_clk, rx_clk, tx_strobe, pout, poe, bosc;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  clk_mode_sel dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_dir(cfg_dir), .cfg_src(cfg_src), .chan_idle(chan_idle),
    .txclk_pin_in(txi), .rxclk_pin_in(rxi), .brg_clk(brg), .dpll_clk(dpll),
    .osc_clk(osc), .tslot_win(tsl), .tx_clk(tx_clk), .rx_clk(rx_clk),
    .tx_strobe(tx_strobe), .txclk_pin_out(pout), .txclk_pin_oe(poe),
    .brg_from_osc(bosc));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] m, input logic d, input logic s);
    @(negedge clk);
    cfg_mode = m; cfg_dir = d; cfg_src = s; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic listed(input logic [2:0] m, input logic d, input logic s);
    if (!d && !s) return (m == 0 || m == 1 || m == 2 || m == 6);
    if (d && s)   return (m == 2 || m == 6);
    if (d)        return (m == 3 || m == 4 || m == 5 || m == 7);
    return 1'b0;
  endfunction

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    txi = 1; rxi = 0; #1;
    chk("R1", "oe", poe, 1'b0);
    chk("R1", "pin_out", pout, 1'b0);
    chk("R1", "tx_clk", tx_clk, 1'b1);
    chk("R1", "rx_clk", rx_clk, 1'b0);
    txi = 0; rxi = 1; #1;
    chk("R1", "tx_clk", tx_clk, 1'b0);
    chk("R1", "rx_clk", rx_clk, 1'b1);
  endtask

  task automatic test_idle_gate;
    write_cfg(3'd0, 1'b0, 1'b0);
    chan_idle = 1'b0;
    write_cfg(3'd4, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2", "oe held while busy", poe, 1'b0);
    chk("R2", "osc flag held", bosc, 1'b0);
    chan_idle = 1'b1;
    @(negedge clk);
    chk("R2", "oe applied at idle", poe, 1'b1);
    chk("R2", "osc flag applied", bosc, 1'b1);
  endtask

  task automatic test_sweep;
    for (int c = 0; c < 32; c++) begin
      logic [2:0] m;
      logic d, s;
      m = c[4:2]; d = c[1]; s = c[0];
      write_cfg(m, d, s);
      for (int p = 0; p < 64; p++) begin
        logic etx, eout, estb, erx;
        {txi, rxi, brg, dpll, osc, tsl} = p[5:0];
        #1;
        etx = rxi; eout = 1'b0;
        if (!d && !s && (m == 0 || m == 2 || m == 6)) etx = txi;
        if (d && s && (m == 2 || m == 6)) begin etx = brg; eout = brg; end
        if (d && !s) begin
          if (m == 3 || m == 7) begin etx = dpll; eout = dpll; end
          if (m == 4) begin etx = osc; eout = osc; end
          if (m == 5) eout = tsl;
        end
        estb = (m == 1 && !d && !s) ? txi : 1'b0;
        case (m)
          3'd2, 3'd6: erx = brg;
          3'd3, 3'd7: erx = dpll;
          3'd4:       erx = osc;
          default:    erx = rxi;
        endcase
        chk("R3", "oe", poe, d);
        if (!listed(m, d, s)) begin
          chk("R9", "tx_clk default", tx_clk, etx);
          chk("R9", "pin_out default", pout, eout);
        end else if (!d) begin
          chk("R4", "tx_clk pin input", tx_clk, etx);
          chk("R3", "pin_out quiet", pout, eout);
        end else if (s) begin
          chk("R5", "tx_clk brg", tx_clk, etx);
          chk("R5", "pin_out brg", pout, eout);
        end else begin
          chk("R6", "tx_clk driven", tx_clk, etx);
          chk("R6", "pin_out driven", pout, eout);
        end
        chk("R4", "tx_strobe", tx_strobe, estb);
        chk("R7", "rx_clk", rx_clk, erx);
        chk("R8", "brg_from_osc", bosc, (m == 4 || m == 6 || m == 7));
      end
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_idle_gate();
    test_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule